// File: doc/BRIEF.md
# SRAM Sleep Mode Power Controller

This block sequences a synchronous SRAM into and out of a low-power sleep state. A sleep request arrives on an asynchronous, active-high pin; the block brings it into the clock domain through a flop chain, waits for any access still in flight, then counts a short entry delay before declaring sleep. While asleep it disables the command path and releases the data outputs to high impedance. The storage array and registered address and control state live elsewhere and are not touched.

When the request is withdrawn, the block passes through a recovery window of fixed length before normal operation returns. During that window only Deselect and Read commands are accepted. A Write is flagged as illegal and its input enable is withheld, so the access never reaches the array. A request that is withdrawn before sleep is reached aborts the entry and leaves the part active.

Command encoding on `cmd_i`: 2'b00 Deselect, 2'b01 Read, 2'b10 Write, 2'b11 reserved and handled as Deselect.

Top module: `sram_sleep_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released with `zz_i` low, the block is active: `sleep_o`=0, `in_en_o`=1, `out_en_o`=1, `recov_o`=0, `illegal_o`=0.
- R2: With `zz_i` held high and `busy_i` low, `sleep_o` rises on the (SYNC_STAGES + 1 + ENTRY_CYCLES)-th rising edge after the first edge that samples `zz_i` high (5 edges with defaults); before that the outputs stay at their active values.
- R3: While `sleep_o` is 1, `in_en_o` and `out_en_o` are 0 and `illegal_o` is 0 for every value of `cmd_i`.
- R4: Once asleep, the block stays asleep for as long as `zz_i` stays high; `cmd_i` and `busy_i` have no effect.
- R5: After `zz_i` falls while asleep, `sleep_o` stays 1 for SYNC_STAGES + 1 edges, then `recov_o` is 1 for exactly WAKE_CYCLES cycles, then the block is active again.
- R6: During recovery, a Write (`cmd_i`=2'b10) drives `illegal_o`=1 and `in_en_o`=0, while `out_en_o` stays 1.
- R7: During recovery, Deselect (2'b00), Read (2'b01) and reserved 2'b11 give `illegal_o`=0 and `in_en_o`=1.
- R8: While `busy_i` is high the block stays active despite a synchronized sleep request; the entry delay starts on the first edge that samples `busy_i` low.
- R9: If the synchronized request falls before sleep is reached, the block returns to active without asserting `sleep_o`.
- R10: Outside recovery and sleep, a Write is never flagged: `illegal_o`=0 and `in_en_o`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| zz_i | input | 1 | Asynchronous sleep request, active high |
| cmd_i | input | 2 | Decoded command (00 Deselect, 01 Read, 10 Write, 11 reserved) |
| busy_i | input | 1 | An access is still in progress |
| sleep_o | output | 1 | Block is in sleep |
| in_en_o | output | 1 | Command inputs enabled |
| out_en_o | output | 1 | Data outputs driven (0 = high impedance) |
| recov_o | output | 1 | Recovery window in progress |
| illegal_o | output | 1 | Write attempted during recovery |

## Verification
The bench builds the block with its default parameters: two synchronizer stages, a two-cycle entry delay and a two-cycle wake delay. These short settings put every state boundary within a handful of cycles of the stimulus, so a single run reaches the exact edge where sleep begins, the last sleeping cycle before recovery, both recovery cycles with each command value, an entry aborted mid-count and an entry held off by a pending access. The per-cycle expectations are derived from the latency formulas in the requirements evaluated at these values.

// File: rtl/sram_sleep_pkg.sv
// Shared types for the SRAM sleep controller.
// Assumes the command decode upstream produces the 2-bit code below.
package sram_sleep_pkg;

    typedef enum logic [1:0] {
        CMD_DESEL = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_RSVD  = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        ST_ACTIVE     = 2'b00,
        ST_ENTERING   = 2'b01,
        ST_SLEEP      = 2'b10,
        ST_RECOVERING = 2'b11
    } pwr_state_e;

endpackage

// File: rtl/zz_sync.sv
// Flop-chain synchronizer for the asynchronous sleep request.
// Assumes STAGES >= 2; output is the last stage, cleared by reset.
module zz_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the request through the chain, one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_i};
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/delay_counter.sv
// Up-counter used to time the entry and wake delays.
// Assumes the controller clears it on each state change that starts a delay.
module delay_counter #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [WIDTH-1:0] count_o
);

    // Clear has priority over increment.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) count_o <= '0;
        else if (inc_i)      count_o <= count_o + 1'b1;
    end

endmodule

// File: rtl/sleep_fsm.sv
// Power-state machine: ACTIVE -> ENTERING -> SLEEP -> RECOVERING -> ACTIVE.
// Assumes zz_s_i is already synchronized and cnt_i comes from a counter
// that this module clears and advances.
module sleep_fsm
    import sram_sleep_pkg::*;
#(
    parameter int ENTRY_CYCLES = 2,
    parameter int WAKE_CYCLES  = 2,
    parameter int CW           = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          zz_s_i,
    input  logic          busy_i,
    input  logic [CW-1:0] cnt_i,
    output logic          cnt_clr_o,
    output logic          cnt_inc_o,
    output pwr_state_e    state_o
);

    localparam logic [CW-1:0] ENTRY_LAST = CW'(ENTRY_CYCLES - 1);
    localparam logic [CW-1:0] WAKE_LAST  = CW'(WAKE_CYCLES - 1);

    pwr_state_e state_q, state_d;

    // Next-state and counter control.
    always_comb begin
        state_d   = state_q;
        cnt_clr_o = 1'b0;
        cnt_inc_o = 1'b0;
        unique case (state_q)
            ST_ACTIVE: begin
                if (zz_s_i && !busy_i) begin
                    state_d   = ST_ENTERING;
                    cnt_clr_o = 1'b1;
                end
            end
            ST_ENTERING: begin
                if (!zz_s_i)                  state_d   = ST_ACTIVE;
                else if (cnt_i == ENTRY_LAST) state_d   = ST_SLEEP;
                else                          cnt_inc_o = 1'b1;
            end
            ST_SLEEP: begin
                if (!zz_s_i) begin
                    state_d   = ST_RECOVERING;
                    cnt_clr_o = 1'b1;
                end
            end
            ST_RECOVERING: begin
                if (cnt_i == WAKE_LAST) state_d   = ST_ACTIVE;
                else                    cnt_inc_o = 1'b1;
            end
            default: state_d = ST_ACTIVE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ACTIVE;
        else        state_q <= state_d;
    end

    assign state_o = state_q;

    // Sleep is only ever reached from the entry delay.
    assert_sleep_via_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && $past(state_q) != ST_SLEEP) |-> $past(state_q) == ST_ENTERING);

    // Sleep holds while the synchronized request stays high.
    assert_sleep_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SLEEP && zz_s_i) |=> state_q == ST_SLEEP);

    // Leaving sleep always passes through recovery.
    assert_exit_via_recovery_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_SLEEP && state_q != ST_SLEEP) |-> state_q == ST_RECOVERING);

    // A pending access holds the block active.
    assert_busy_defers_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ACTIVE && busy_i) |=> state_q == ST_ACTIVE);

    // A withdrawn request during entry returns to active.
    assert_abort_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ENTERING && !zz_s_i) |=> state_q == ST_ACTIVE);

endmodule

// File: rtl/sram_sleep_ctrl.sv
// Top of the SRAM sleep controller: synchronizes the sleep request,
// times entry and wake delays, gates the command and data paths, and
// flags writes issued during recovery.
// Assumes SYNC_STAGES >= 2, ENTRY_CYCLES >= 1, WAKE_CYCLES >= 1.
module sram_sleep_ctrl
    import sram_sleep_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int ENTRY_CYCLES = 2,
    parameter int WAKE_CYCLES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       zz_i,
    input  logic [1:0] cmd_i,
    input  logic       busy_i,
    output logic       sleep_o,
    output logic       in_en_o,
    output logic       out_en_o,
    output logic       recov_o,
    output logic       illegal_o
);

    localparam int MAX_DELAY = (ENTRY_CYCLES > WAKE_CYCLES) ? ENTRY_CYCLES : WAKE_CYCLES;
    localparam int CW        = (MAX_DELAY < 2) ? 1 : $clog2(MAX_DELAY);

    logic          zz_s;
    logic          cnt_clr, cnt_inc;
    logic [CW-1:0] cnt;
    pwr_state_e    state;
    logic          is_write;

    zz_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (zz_i),
        .sync_o  (zz_s)
    );

    delay_counter #(.WIDTH(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cnt_clr),
        .inc_i   (cnt_inc),
        .count_o (cnt)
    );

    sleep_fsm #(
        .ENTRY_CYCLES (ENTRY_CYCLES),
        .WAKE_CYCLES  (WAKE_CYCLES),
        .CW           (CW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .zz_s_i    (zz_s),
        .busy_i    (busy_i),
        .cnt_i     (cnt),
        .cnt_clr_o (cnt_clr),
        .cnt_inc_o (cnt_inc),
        .state_o   (state)
    );

    // Output decode from state and the current command.
    always_comb begin
        is_write  = (cmd_e'(cmd_i) == CMD_WRITE);
        sleep_o   = (state == ST_SLEEP);
        recov_o   = (state == ST_RECOVERING);
        illegal_o = recov_o && is_write;
        out_en_o  = !sleep_o;
        in_en_o   = !sleep_o && !illegal_o;
    end

    // The wake delay never runs past its bound.
    assert_wake_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        recov_o |-> int'(cnt) < WAKE_CYCLES);

    // A flagged write is always blocked and only seen in recovery.
    assert_illegal_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!in_en_o && recov_o && out_en_o));

    // Sleep releases the data outputs.
    assert_sleep_hiz_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |-> (!out_en_o && !in_en_o && !illegal_o));

endmodule

// File: tb/sram_sleep_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_sleep_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       zz_i = 1'b0;
    logic [1:0] cmd_i = 2'b00;
    logic       busy_i = 1'b0;
    logic       sleep_o, in_en_o, out_en_o, recov_o, illegal_o;

    // Expected vector order: {sleep, in_en, out_en, recov, illegal}
    localparam logic [4:0] NORM = 5'b01100;
    localparam logic [4:0] SLP  = 5'b10000;
    localparam logic [4:0] REC  = 5'b01110;
    localparam logic [4:0] RECW = 5'b00111;

    typedef struct {
        logic [4:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    event  chk_ev;
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;

    always #5 clk = ~clk;

    sram_sleep_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .zz_i      (zz_i),
        .cmd_i     (cmd_i),
        .busy_i    (busy_i),
        .sleep_o   (sleep_o),
        .in_en_o   (in_en_o),
        .out_en_o  (out_en_o),
        .recov_o   (recov_o),
        .illegal_o (illegal_o)
    );

    // Driver: apply one cycle of stimulus and queue the expected outputs.
    task automatic step(input logic z, input logic [1:0] c, input logic b,
                        input logic [4:0] e, input string t);
        item_t it;
        @(negedge clk);
        zz_i   = z;
        cmd_i  = c;
        busy_i = b;
        it.exp = e;
        it.tag = t;
        q.push_back(it);
        ->chk_ev;
    endtask

    // Monitor: compare outputs against the oldest expectation.
    initial begin
        forever begin
            item_t it;
            logic [4:0] act;
            @(chk_ev);
            #1;
            it  = q.pop_front();
            act = {sleep_o, in_en_o, out_en_o, recov_o, illegal_o};
            n_checks++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, even with a request and a write present.
        step(1'b0, 2'b10, 1'b0, NORM, "R1 reset");
        step(1'b1, 2'b10, 1'b0, NORM, "R1 reset zz high");
        step(1'b0, 2'b00, 1'b0, NORM, "R1 reset");
        @(negedge clk) rst_n = 1'b1;
        step(1'b0, 2'b01, 1'b0, NORM, "R1 after release");

        // R2/R10: entry latency; sleep visible five edges after request.
        step(1'b1, 2'b01, 1'b0, NORM, "R2 entry edge0");
        step(1'b1, 2'b10, 1'b0, NORM, "R10 write active");
        step(1'b1, 2'b01, 1'b0, NORM, "R2 entry");
        step(1'b1, 2'b00, 1'b0, NORM, "R2 entry");
        step(1'b1, 2'b10, 1'b0, NORM, "R2 last active cycle");
        // R3/R4: asleep, commands and busy have no effect.
        step(1'b1, 2'b10, 1'b0, SLP,  "R2 sleep reached");
        step(1'b1, 2'b01, 1'b1, SLP,  "R3 read asleep");
        step(1'b1, 2'b11, 1'b0, SLP,  "R4 sleep holds");
        step(1'b1, 2'b10, 1'b1, SLP,  "R3 write asleep");
        // R5: wake sequence.
        step(1'b0, 2'b10, 1'b0, SLP,  "R5 still asleep");
        step(1'b0, 2'b01, 1'b0, SLP,  "R5 still asleep");
        step(1'b0, 2'b00, 1'b0, SLP,  "R5 last sleep cycle");
        step(1'b0, 2'b10, 1'b0, RECW, "R6 write in recovery");
        step(1'b0, 2'b01, 1'b0, REC,  "R7 read in recovery");
        step(1'b0, 2'b10, 1'b0, NORM, "R5 active after wake");
        step(1'b0, 2'b00, 1'b0, NORM, "R5 active");

        // R7: deselect and reserved code during recovery.
        for (int i = 0; i < 5; i++) step(1'b1, 2'b00, 1'b0, NORM, "R2 entry");
        step(1'b1, 2'b00, 1'b0, SLP,  "R2 sleep");
        step(1'b0, 2'b00, 1'b0, SLP,  "R5 asleep");
        step(1'b0, 2'b00, 1'b0, SLP,  "R5 asleep");
        step(1'b0, 2'b00, 1'b0, SLP,  "R5 asleep");
        step(1'b0, 2'b00, 1'b0, REC,  "R7 deselect in recovery");
        step(1'b0, 2'b11, 1'b0, REC,  "R7 reserved in recovery");
        step(1'b0, 2'b10, 1'b0, NORM, "R10 write after recovery");

        // R9: request withdrawn during the entry delay.
        step(1'b1, 2'b00, 1'b0, NORM, "R9 pulse");
        step(1'b1, 2'b00, 1'b0, NORM, "R9 pulse");
        for (int i = 0; i < 8; i++) step(1'b0, 2'b01, 1'b0, NORM, "R9 no sleep");

        // R8: pending access defers entry.
        for (int i = 0; i < 6; i++) step(1'b1, 2'b01, 1'b1, NORM, "R8 busy holds active");
        step(1'b1, 2'b00, 1'b0, NORM, "R8 busy released");
        step(1'b1, 2'b00, 1'b0, NORM, "R8 entering");
        step(1'b1, 2'b00, 1'b0, NORM, "R8 entering");
        step(1'b1, 2'b00, 1'b1, SLP,  "R8 sleep after release");
        step(1'b0, 2'b00, 1'b1, SLP,  "R4 asleep busy");
        step(1'b0, 2'b00, 1'b0, SLP,  "R5 asleep");
        step(1'b0, 2'b00, 1'b0, SLP,  "R5 asleep");
        step(1'b0, 2'b10, 1'b0, RECW, "R6 write blocked");
        step(1'b0, 2'b10, 1'b0, RECW, "R6 write blocked");
        step(1'b0, 2'b10, 1'b0, NORM, "R10 write active");

        @(negedge clk);
        #2;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule